// File: doc/BRIEF.md
# Privileged CSR File with Write Legalisation

This block stores the machine-level and supervisor-level control and status registers of a 32-bit RISC-V hart. Software writes arrive on a synchronous port made of an address, a data word and an enable. A combinational read port uses the same address. Every write passes through a per-register legalisation rule, so only implemented fields ever change. Some writes are rejected whole, and some are rejected only for one field.

The supervisor status, interrupt-enable and interrupt-pending registers have no storage of their own. They are masked windows onto the machine registers: the status window uses a fixed field mask, and the interrupt windows use the interrupt delegation register.

When a write changes state that affects address translation, the block raises a one-cycle flush strobe for the TLB. An address the block does not implement raises an illegal flag and has no effect.

Top module: `csrFile`

## Requirements
- R1: A write to mstatus (0x300) changes only SIE(1), MIE(3), SPIE(5), MPIE(7), SPP(8), MPP(12:11), FS(14:13), MPRV(17), SUM(18) and MXR(19); every other bit keeps its value, apart from the summary bit SD(31) set by R3.
- R2: A status write whose MPP value is 2 leaves MPP unchanged while the remaining fields still update. A value of 1 is rejected the same way when misa bit 18 is clear, and a value of 0 when misa bit 20 is clear.
- R3: After any status write, a nonzero FS is forced to 3, and SD(31) equals (FS==3) or (XS(16:15)==3).
- R4: mie (0x304) updates only bits 1, 3, 5, 7 and 9. mideleg (0x303) updates only bits 1, 5 and 9. All other bits of both read as zero.
- R5: medeleg (0x302) updates only bits 0 to 13 and bit 15; all other bits read as zero.
- R6: A write to mtvec (0x305) or stvec (0x105) is stored whole when data[1:0] is 0, and is ignored otherwise.
- R7: sstatus (0x100) reads mstatus ANDed with 0x800DE133. A write to it updates only those of its fields that are also writable in mstatus (bits 1, 5, 8, 13, 14, 18, 19), and R3 applies.
- R8: sie (0x104) and sip (0x144) read mie and mip ANDed with mideleg, and a write to them changes mie or mip only at bits whose mideleg bit is 1.
- R9: A write to mip (0x344) changes only bits 1 and 5. Writes to misa (0x301), mcycle (0xB00), minstret (0xB02) and mhartid (0xF14) have no effect. misa reads as the MISA_VAL parameter, the two counters read 0, and mhartid reads the hartId input.
- R10: A write to satp (0x180) is stored only when it differs from the current value (mode bit 31, ASID bits 30:22, PPN bits 21:0). An accepted write raises tlbFlush for exactly the one cycle after the write edge.
- R11: A status write (through mstatus or sstatus) that changes MXR, SUM, MPRV or MPP raises tlbFlush for exactly the one cycle after the write edge; tlbFlush is low in all other cycles.
- R12: After reset every register reads zero, except misa (MISA_VAL) and mhartid (hartId).
- R13: An address outside the implemented set drives illegal high, reads 0, and leaves all state unchanged when written.
- R14: mscratch, mepc, mcause, mtval (0x340 to 0x343) and sscratch, sepc, scause, stval (0x140 to 0x143) store all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | Register address shared by the read and write ports |
| wrEn | input | 1 | Write enable; the write takes effect at the next rising edge |
| wrData | input | 32 | Raw write value before legalisation |
| hartId | input | 32 | Hart identifier returned by mhartid |
| rdData | output | 32 | Combinational read value for csrAddr (value before any pending write) |
| illegal | output | 1 | High while csrAddr is not an implemented register |
| tlbFlush | output | 1 | One-cycle strobe after a translation-relevant change |

## Verification
A wrong legalisation mask or a mis-aliased supervisor view leaves a bad value in a machine register. That value shows on rdData at the first read of that register or of any window onto it, one cycle after the write edge. Errors in the translation-change detection show on tlbFlush in the very cycle after the write. The flush output is therefore compared against the model on every clock, and every register is read back after each directed step and during a long run of random writes.

// File: rtl/csrFilePkg.sv
package csrFilePkg;
  localparam int XLEN   = 32;
  localparam int ADDR_W = 12;

  typedef logic [XLEN-1:0]   word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_MSTATUS, SEL_MISA, SEL_MEDELEG, SEL_MIDELEG, SEL_MIE,
    SEL_MTVEC, SEL_MSCRATCH, SEL_MEPC, SEL_MCAUSE, SEL_MTVAL, SEL_MIP,
    SEL_MHARTID, SEL_MCYCLE, SEL_MINSTRET, SEL_SSTATUS, SEL_SIE, SEL_STVEC,
    SEL_SSCRATCH, SEL_SEPC, SEL_SCAUSE, SEL_STVAL, SEL_SIP, SEL_SATP
  } csrSel_t;

  // strobes handed from decode to the register datapath
  typedef struct packed {
    csrSel_t sel;
    logic    wrStrobe;
    logic    illegal;
  } csrCtrl_t;

  localparam addr_t A_MSTATUS  = 12'h300;
  localparam addr_t A_MISA     = 12'h301;
  localparam addr_t A_MEDELEG  = 12'h302;
  localparam addr_t A_MIDELEG  = 12'h303;
  localparam addr_t A_MIE      = 12'h304;
  localparam addr_t A_MTVEC    = 12'h305;
  localparam addr_t A_MSCRATCH = 12'h340;
  localparam addr_t A_MEPC     = 12'h341;
  localparam addr_t A_MCAUSE   = 12'h342;
  localparam addr_t A_MTVAL    = 12'h343;
  localparam addr_t A_MIP      = 12'h344;
  localparam addr_t A_MHARTID  = 12'hF14;
  localparam addr_t A_MCYCLE   = 12'hB00;
  localparam addr_t A_MINSTRET = 12'hB02;
  localparam addr_t A_SSTATUS  = 12'h100;
  localparam addr_t A_SIE      = 12'h104;
  localparam addr_t A_STVEC    = 12'h105;
  localparam addr_t A_SSCRATCH = 12'h140;
  localparam addr_t A_SEPC     = 12'h141;
  localparam addr_t A_SCAUSE   = 12'h142;
  localparam addr_t A_STVAL    = 12'h143;
  localparam addr_t A_SIP      = 12'h144;
  localparam addr_t A_SATP     = 12'h180;

  // status field positions
  localparam int MPP_LO = 11;
  localparam int FS_LO  = 13;
  localparam int XS_LO  = 15;
  localparam int SD_BIT = XLEN - 1;

  localparam word_t STATUS_WMASK  = 32'h000E_79AA;
  localparam word_t SSTATUS_VIEW  = 32'h800D_E133;
  localparam word_t XLATE_MASK    = 32'h000E_1800; // MXR SUM MPRV MPP
  localparam word_t IE_WMASK      = 32'h0000_02AA;
  localparam word_t IDELEG_WMASK  = 32'h0000_0222;
  localparam word_t EDELEG_WMASK  = 32'h0000_BFFF;
  localparam word_t IP_WMASK      = 32'h0000_0022;
endpackage

// File: rtl/csrFileCtrl.sv
module csrFileCtrl
  import csrFilePkg::*;
(
  input  addr_t    csrAddr,
  input  logic     wrEn,
  output csrCtrl_t ctrl
);
  csrSel_t sel;

  always_comb begin
    unique case (csrAddr)
      A_MSTATUS:  sel = SEL_MSTATUS;
      A_MISA:     sel = SEL_MISA;
      A_MEDELEG:  sel = SEL_MEDELEG;
      A_MIDELEG:  sel = SEL_MIDELEG;
      A_MIE:      sel = SEL_MIE;
      A_MTVEC:    sel = SEL_MTVEC;
      A_MSCRATCH: sel = SEL_MSCRATCH;
      A_MEPC:     sel = SEL_MEPC;
      A_MCAUSE:   sel = SEL_MCAUSE;
      A_MTVAL:    sel = SEL_MTVAL;
      A_MIP:      sel = SEL_MIP;
      A_MHARTID:  sel = SEL_MHARTID;
      A_MCYCLE:   sel = SEL_MCYCLE;
      A_MINSTRET: sel = SEL_MINSTRET;
      A_SSTATUS:  sel = SEL_SSTATUS;
      A_SIE:      sel = SEL_SIE;
      A_STVEC:    sel = SEL_STVEC;
      A_SSCRATCH: sel = SEL_SSCRATCH;
      A_SEPC:     sel = SEL_SEPC;
      A_SCAUSE:   sel = SEL_SCAUSE;
      A_STVAL:    sel = SEL_STVAL;
      A_SIP:      sel = SEL_SIP;
      A_SATP:     sel = SEL_SATP;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    ctrl.sel      = sel;
    ctrl.illegal  = (sel == SEL_NONE);
    ctrl.wrStrobe = wrEn && (sel != SEL_NONE);
  end
endmodule

// File: rtl/csrFileRegs.sv
module csrFileRegs
  import csrFilePkg::*;
#(
  parameter word_t MISA_VAL = 32'h4014_1100
) (
  input  logic     clk,
  input  logic     rstN,
  input  csrCtrl_t ctrl,
  input  word_t    wrData,
  input  word_t    hartId,
  output word_t    rdData,
  output logic     tlbFlush
);
  localparam logic HAS_S     = MISA_VAL[18];
  localparam logic HAS_U     = MISA_VAL[20];
  localparam int   NUM_PLAIN = 8;
  localparam csrSel_t PLAIN_SELS [NUM_PLAIN] = '{
    SEL_MSCRATCH, SEL_MEPC, SEL_MCAUSE, SEL_MTVAL,
    SEL_SSCRATCH, SEL_SEPC, SEL_SCAUSE, SEL_STVAL};

  word_t mstatusQ, medelegQ, midelegQ, mieQ, mipQ, mtvecQ, stvecQ, satpQ;
  word_t plainQ [NUM_PLAIN];
  logic  flushQ;

  word_t   statusMask, statusNext, ieNext, ipNext, delegIp, plainRd;
  logic    mppOk, statusWr, satpWr, flushNext;
  logic [1:0] mppReq;

  function automatic logic isSel(csrSel_t s);
    return ctrl.wrStrobe && (ctrl.sel == s);
  endfunction

  // status legaliser, shared by the machine and supervisor paths
  always_comb begin
    mppReq = wrData[MPP_LO+1:MPP_LO];
    mppOk  = (mppReq == 2'b11) || (mppReq == 2'b01 && HAS_S) || (mppReq == 2'b00 && HAS_U);
    statusMask = (ctrl.sel == SEL_SSTATUS) ? (STATUS_WMASK & SSTATUS_VIEW) : STATUS_WMASK;
    if (!mppOk) statusMask[MPP_LO+1:MPP_LO] = 2'b00;
    statusNext = (mstatusQ & ~statusMask) | (wrData & statusMask);
    if (statusNext[FS_LO+1:FS_LO] != 2'b00) statusNext[FS_LO+1:FS_LO] = 2'b11;
    statusNext[SD_BIT] = (&statusNext[FS_LO+1:FS_LO]) | (&statusNext[XS_LO+1:XS_LO]);
    statusWr  = isSel(SEL_MSTATUS) || isSel(SEL_SSTATUS);
    satpWr    = isSel(SEL_SATP) && (wrData != satpQ);
    flushNext = (statusWr && (((statusNext ^ mstatusQ) & XLATE_MASK) != '0)) || satpWr;
  end

  always_comb begin
    if (ctrl.sel == SEL_SIE) ieNext = (mieQ & ~midelegQ) | (wrData & midelegQ);
    else                     ieNext = (mieQ & ~IE_WMASK) | (wrData & IE_WMASK);
    delegIp = (ctrl.sel == SEL_SIP) ? (midelegQ & IP_WMASK) : IP_WMASK;
    ipNext  = (mipQ & ~delegIp) | (wrData & delegIp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mstatusQ <= '0; medelegQ <= '0; midelegQ <= '0; mieQ <= '0;
      mipQ <= '0; mtvecQ <= '0; stvecQ <= '0; satpQ <= '0; flushQ <= 1'b0;
      for (int i = 0; i < NUM_PLAIN; i++) plainQ[i] <= '0;
    end else begin
      flushQ <= flushNext;
      if (statusWr) mstatusQ <= statusNext;
      if (isSel(SEL_MIE) || isSel(SEL_SIE)) mieQ <= ieNext;
      if (isSel(SEL_MIP) || isSel(SEL_SIP)) mipQ <= ipNext;
      if (isSel(SEL_MIDELEG)) midelegQ <= wrData & IDELEG_WMASK;
      if (isSel(SEL_MEDELEG)) medelegQ <= wrData & EDELEG_WMASK;
      if (isSel(SEL_MTVEC) && wrData[1:0] == 2'b00) mtvecQ <= wrData;
      if (isSel(SEL_STVEC) && wrData[1:0] == 2'b00) stvecQ <= wrData;
      if (satpWr) satpQ <= wrData;
      for (int i = 0; i < NUM_PLAIN; i++)
        if (isSel(PLAIN_SELS[i])) plainQ[i] <= wrData;
    end
  end

  always_comb begin
    plainRd = '0;
    for (int i = 0; i < NUM_PLAIN; i++)
      if (ctrl.sel == PLAIN_SELS[i]) plainRd = plainQ[i];
  end

  always_comb begin
    case (ctrl.sel)
      SEL_MSTATUS: rdData = mstatusQ;
      SEL_SSTATUS: rdData = mstatusQ & SSTATUS_VIEW;
      SEL_MISA:    rdData = MISA_VAL;
      SEL_MEDELEG: rdData = medelegQ;
      SEL_MIDELEG: rdData = midelegQ;
      SEL_MIE:     rdData = mieQ;
      SEL_SIE:     rdData = mieQ & midelegQ;
      SEL_MIP:     rdData = mipQ;
      SEL_SIP:     rdData = mipQ & midelegQ;
      SEL_MTVEC:   rdData = mtvecQ;
      SEL_STVEC:   rdData = stvecQ;
      SEL_SATP:    rdData = satpQ;
      SEL_MHARTID: rdData = hartId;
      default:     rdData = plainRd;
    endcase
  end

  assign tlbFlush = flushQ;

  // checks next to the state they guard
  assert_status_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusWr |=> (((mstatusQ ^ $past(mstatusQ)) & ~STATUS_WMASK & ~(word_t'(1) << SD_BIT)) == '0));
  assert_mpp_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    mstatusQ[MPP_LO+1:MPP_LO] != 2'b10);
  assert_fs_dirty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mstatusQ[FS_LO+1:FS_LO] == 2'b00 || mstatusQ[FS_LO+1:FS_LO] == 2'b11) &&
    (mstatusQ[SD_BIT] == ((&mstatusQ[FS_LO+1:FS_LO]) | (&mstatusQ[XS_LO+1:XS_LO]))));
  assert_ie_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((mieQ & ~IE_WMASK) == '0) && ((midelegQ & ~IDELEG_WMASK) == '0));
  assert_edeleg_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (medelegQ & ~EDELEG_WMASK) == '0);
  assert_tvec_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrStrobe && ctrl.sel == SEL_MTVEC && wrData[1:0] != 2'b00) |=> $stable(mtvecQ));
  assert_ip_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mipQ & ~IP_WMASK) == '0);
  assert_flush_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> $past(ctrl.wrStrobe));
  assert_unknown_inert_R13: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.illegal |=> ($stable(mstatusQ) && $stable(satpQ) && $stable(mieQ) && $stable(mtvecQ)));
endmodule

// File: rtl/csrFile.sv
module csrFile
  import csrFilePkg::*;
#(
  parameter logic [31:0] MISA_VAL = 32'h4014_1100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] csrAddr,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic [31:0] hartId,
  output logic [31:0] rdData,
  output logic        illegal,
  output logic        tlbFlush
);
  csrCtrl_t ctrl;

  csrFileCtrl ctrl_i (
    .csrAddr (csrAddr),
    .wrEn    (wrEn),
    .ctrl    (ctrl)
  );

  csrFileRegs #(.MISA_VAL(MISA_VAL)) regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wrData   (wrData),
    .hartId   (hartId),
    .rdData   (rdData),
    .tlbFlush (tlbFlush)
  );

  assign illegal = ctrl.illegal;
endmodule

// File: tb/csrFile_tb_top.sv
module csrFile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MISA = 32'h4014_1100;
  localparam logic [31:0] HART = 32'h0000_0005;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] csrAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        illegal, tlbFlush;

  int checks = 0;
  int fails = 0;
  bit pendFlush = 0;
  bit expFlush = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] mMs = '0, mEdel = '0, mIdel = '0, mIe = '0, mIp = '0;
  logic [31:0] mTvec = '0, sTvec = '0, mSatp = '0;
  logic [31:0] plain [int];

  int known [23] = '{'h300, 'h301, 'h302, 'h303, 'h304, 'h305, 'h340, 'h341,
                     'h342, 'h343, 'h344, 'hF14, 'hB00, 'hB02, 'h100, 'h104,
                     'h105, 'h140, 'h141, 'h142, 'h143, 'h144, 'h180};

  csrFile #(.MISA_VAL(MISA)) dut_i (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .wrEn(wrEn), .wrData(wrData),
    .hartId(HART), .rdData(rdData), .illegal(illegal), .tlbFlush(tlbFlush));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isKnown(int a);
    foreach (known[i]) if (known[i] == a) return 1;
    return 0;
  endfunction

  function automatic bit isPlain(int a);
    return (a >= 'h340 && a <= 'h343) || (a >= 'h140 && a <= 'h143);
  endfunction

  function automatic logic [31:0] statusAfter(logic [31:0] old, logic [31:0] d, bit viaSup);
    int mBits [12] = '{1, 3, 5, 7, 8, 11, 12, 13, 14, 17, 18, 19};
    int sBits [7]  = '{1, 5, 8, 13, 14, 18, 19};
    logic [31:0] n;
    n = old;
    if (viaSup) foreach (sBits[i]) n[sBits[i]] = d[sBits[i]];
    else        foreach (mBits[i]) n[mBits[i]] = d[mBits[i]];
    if (n[12:11] == 2'b10 || (n[12:11] == 2'b01 && !MISA[18]) ||
        (n[12:11] == 2'b00 && !MISA[20]))
      n[12:11] = old[12:11];
    if (n[14:13] != 2'b00) n[14:13] = 2'b11;
    n[31] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
    return n;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    case (a)
      'h300: return mMs;
      'h100: return mMs & 32'h800D_E133;
      'h301: return MISA;
      'h302: return mEdel;
      'h303: return mIdel;
      'h304: return mIe;
      'h104: return mIe & mIdel;
      'h344: return mIp;
      'h144: return mIp & mIdel;
      'h305: return mTvec;
      'h105: return sTvec;
      'h180: return mSatp;
      'hF14: return HART;
      default: return (isPlain(a) && plain.exists(a)) ? plain[a] : 32'h0;
    endcase
  endfunction

  // updates the model and returns whether a flush is expected
  function automatic bit modelWrite(int a, logic [31:0] d);
    logic [31:0] n;
    bit fl = 0;
    int ib [3] = '{1, 5, 9};
    case (a)
      'h300, 'h100: begin
        n = statusAfter(mMs, d, a == 'h100);
        if (((n ^ mMs) & 32'h000E_1800) != 0) fl = 1;
        mMs = n;
      end
      'h304: mIe = d & 32'h2AA;
      'h104: foreach (ib[i]) if (mIdel[ib[i]]) mIe[ib[i]] = d[ib[i]];
      'h303: mIdel = d & 32'h222;
      'h302: mEdel = d & 32'hBFFF;
      'h344: begin mIp[1] = d[1]; mIp[5] = d[5]; end
      'h144: begin
        if (mIdel[1]) mIp[1] = d[1];
        if (mIdel[5]) mIp[5] = d[5];
      end
      'h305: if (d[1:0] == 2'b00) mTvec = d;
      'h105: if (d[1:0] == 2'b00) sTvec = d;
      'h180: if (d != mSatp) begin mSatp = d; fl = 1; end
      default: if (isPlain(a)) plain[a] = d;
    endcase
    return fl;
  endfunction

  task automatic doWrite(int a, logic [31:0] d);
    @(negedge clk);
    csrAddr = a[11:0];
    wrData = d;
    wrEn = 1'b1;
    pendFlush = modelWrite(a, d);
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    pendFlush = 0;
  endtask

  task automatic doRead(int a, string tag);
    logic [31:0] e;
    @(negedge clk);
    csrAddr = a[11:0];
    wrEn = 1'b0;
    #1;
    e = isKnown(a) ? modelRead(a) : 32'h0;
    check(rdData === e, tag, rdData, e);
    check(illegal === !isKnown(a), {tag, " illegal"}, {31'h0, illegal}, {31'h0, !isKnown(a)});
  endtask

  task automatic readAll(string tag);
    foreach (known[i]) doRead(known[i], tag);
  endtask

  // flush strobe compared with the model on every clock (R10, R11)
  always @(posedge clk) expFlush <= rstN ? pendFlush : 1'b0;
  always @(negedge clk)
    if (rstN && !done)
      check(tlbFlush === expFlush, "R10_R11 flush strobe", {31'h0, tlbFlush}, {31'h0, expFlush});

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    readAll("R12 reset value");

    // R1 R3 R11: all-ones status write
    doWrite('h300, 32'hFFFF_FFFF);
    doRead('h300, "R1 status write mask");
    // R2: reserved MPP rejected, rest applied
    doWrite('h300, 32'h0000_1008);
    doRead('h300, "R2 reserved MPP kept");
    // R3: FS=1 becomes dirty
    doWrite('h300, 32'h0000_2000);
    doRead('h300, "R3 FS forced dirty");
    doWrite('h300, 32'h0000_0800);
    doRead('h300, "R3 FS off clears SD");

    // R4 R5
    doWrite('h304, 32'hFFFF_FFFF);
    doRead('h304, "R4 mie mask");
    doWrite('h303, 32'hFFFF_FFFF);
    doRead('h303, "R4 mideleg mask");
    doWrite('h302, 32'hFFFF_FFFF);
    doRead('h302, "R5 medeleg mask");

    // R6
    doWrite('h305, 32'h8000_0101);
    doRead('h305, "R6 mtvec vectored ignored");
    doWrite('h305, 32'h8000_0100);
    doRead('h305, "R6 mtvec direct taken");
    doWrite('h105, 32'h0000_4002);
    doRead('h105, "R6 stvec reserved ignored");
    doWrite('h105, 32'h0000_4000);
    doRead('h105, "R6 stvec direct taken");

    // R7
    doWrite('h100, 32'hFFFF_FFFF);
    doRead('h100, "R7 sstatus view");
    doRead('h300, "R7 sstatus through mstatus");

    // R8
    doWrite('h104, 32'h0000_0000);
    doRead('h304, "R8 sie clears delegated only");
    doWrite('h144, 32'hFFFF_FFFF);
    doRead('h144, "R8 sip view");
    doWrite('h303, 32'h0000_0020);
    doRead('h104, "R8 sie after deleg change");
    doWrite('h144, 32'h0000_0000);
    doRead('h344, "R8 sip write limited by deleg");

    // R9
    doWrite('h344, 32'hFFFF_FFFF);
    doRead('h344, "R9 mip software bits");
    doWrite('h301, 32'h0000_0000);
    doRead('h301, "R9 misa ignored");
    doWrite('h0B00, 32'h1234_5678);
    doRead('h0B00, "R9 mcycle ignored");
    doWrite('h0B02, 32'h1234_5678);
    doRead('h0B02, "R9 minstret ignored");
    doWrite('hF14, 32'hFFFF_FFFF);
    doRead('hF14, "R9 mhartid ignored");

    // R10
    doWrite('h180, 32'h8040_0123);
    doRead('h180, "R10 satp accepted");
    doWrite('h180, 32'h8040_0123);
    doRead('h180, "R10 satp same value");

    // R14
    foreach (known[i])
      if (isPlain(known[i])) doWrite(known[i], 32'hA5A5_0000 ^ known[i]);
    readAll("R14 plain registers");

    // R13
    doWrite('h7C0, 32'hFFFF_FFFF);
    doRead('h7C0, "R13 unknown address");
    doWrite('h3A0, 32'h0000_0000);
    doRead('h3A0, "R13 unknown address");
    readAll("R13 state unchanged");

    // random mix, every register compared afterward
    for (int k = 0; k < 300; k++) begin
      int a;
      logic [31:0] d;
      a = known[$urandom_range(0, 22)];
      d = $urandom();
      if (k % 3 == 0) d[1:0] = 2'b00;
      doWrite(a, d);
      if (k % 25 == 24) readAll("R1_R14 random sequence");
    end
    readAll("R1_R14 random final");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule